// File: doc/BRIEF.md
# Parallel Port Mode and Pin Control

This block holds the configuration and control state of a host-side parallel port and drives its control pins. Software selects an operating mode with a three-bit code and an extension bit. When the extension bit is set, four otherwise unused code points become the enhanced-parallel-port read mode and three write modes. A new mode normally waits until the handshake engine reports idle. A force bit makes the switch happen at once. The handshake engines are outside this block and are seen only through a busy flag, a five-bit control bus and a data bus.

Every output control signal and every sampled input has its own polarity inversion bit. In manual mode the control pins and the data bus follow the control register directly. Off mode forces fixed levels on the four control pins. A sixteen-bit status word shows the mode in effect, the conditioned input pins and the engine flags. Software reads it to learn when a deferred mode change has completed. A peripheral interrupt flag is set by an event and cleared by an acknowledge bit in the control word.

Top module: `pport_modectl`

## Requirements
- R1: After reset the configuration and control registers are zero. The effective mode is manual (0). pin_seli_n, pin_autofd_n, pin_strb_n and pin_init_n are 1, while pin_data_oe, pin_data and irq_pend are 0.
- R2: A configuration write (cfg_wr) takes mode[2:0] from wdata[2:0] and the extension bit from wdata[3]. The requested code is {wdata[3], wdata[2:0]}. With the extension bit clear, all eight codes are legal. With it set, only 1000, 1101, 1110 and 1111 are legal. mode_o shows the 4-bit code in effect.
- R3: An illegal code in a configuration write leaves the requested mode unchanged. All other configuration fields of that write still take effect.
- R4: When force (wdata[4]) is 0 and eng_busy is 1, mode_o holds its value. A pending code takes effect on the clock edge after the first cycle in which eng_busy is 0.
- R5: When force is 1, a pending code takes effect on the clock edge after the configuration write, whatever the value of eng_busy.
- R6: Manual mode uses control word bits 20:16 as oe, seli, autofd, strb and init, listed from bit 20 down to bit 16, and bits 7:0 as data. An active bit drives its _n pin low and drives pin_data_oe high. pin_data follows the data bits.
- R7: A byte-wide control write (ctl_byte_wr) puts wdata[4:0] into control bits 20:16 in the same order. The data byte is left unchanged.
- R8: Output inversion bits in the configuration word each flip one pin: bit 8 for init, bit 9 for strb, bit 10 for autofd, bit 11 for seli and bit 12 for oe. They apply in every mode except for the four control pins in off mode.
- R9: In off mode (0111), pin_seli_n=0, pin_autofd_n=1, pin_strb_n=1 and pin_init_n=1 regardless of inversion. The data output enable is inactive, so pin_data_oe equals its inversion bit.
- R10: In modes 1 to 4 the init signal comes from the control register. In modes 1 and 2 the autofd signal does too. In every mode other than manual and off, all remaining control signals come from eng_ctl and pin_data comes from eng_data. eng_ctl uses bit 0 for init, 1 for strb, 2 for autofd, 3 for seli and 4 for oe, each active high.
- R11: The layout of status_o is:
  - bit 0: rx_avail
  - bit 1: tx_ready
  - bits 5:2: zero
  - bit 6: the wide bit (wdata[6] of the configuration)
  - bit 7: extension bit of the mode in effect
  - bits 12:8: the input pins sel, fault_n, busy, ack_n and perr, with sel at bit 8 and perr at bit 12
  - bits 15:13: mode[2:0] in effect
  
  Each input is sampled through SYNC_STAGES flops and XORed with its inversion bit, configuration bits 16 to 20 in the same order.
- R12: When the enable bit (wdata[5]) is 0, the effective mode is forced to manual. The control, data and interrupt state are cleared and held at zero, and control writes are ignored.
- R13: A periph_evt pulse sets irq_pend. A full control write with bit 24 set clears irq_pend. If an event arrives in the same cycle as the acknowledge, irq_pend stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| ctl_wr | input | 1 | Full control word write strobe |
| ctl_byte_wr | input | 1 | Byte-wide control field write strobe |
| wdata | input | 32 | Write data for all three writes |
| eng_busy | input | 1 | Handshake engine busy |
| eng_ctl | input | 5 | Control signals requested by the engine, active high |
| eng_data | input | DATA_W | Data bus requested by the engine |
| rx_avail | input | 1 | Engine has received data |
| tx_ready | input | 1 | Engine can accept data |
| periph_evt | input | 1 | Peripheral interrupt event |
| pin_perr | input | 1 | Paper error pin |
| pin_ack_n | input | 1 | Acknowledge pin |
| pin_busy | input | 1 | Busy pin |
| pin_fault_n | input | 1 | Fault pin |
| pin_sel | input | 1 | Select pin |
| pin_seli_n | output | 1 | Select-in pin |
| pin_autofd_n | output | 1 | Auto-feed pin |
| pin_strb_n | output | 1 | Strobe pin |
| pin_init_n | output | 1 | Initialise pin |
| pin_data_oe | output | 1 | Data driver output enable |
| pin_data | output | DATA_W | Data pins |
| mode_o | output | 4 | Mode in effect |
| irq_pend | output | 1 | Peripheral interrupt pending |
| status_o | output | 16 | Status word |

## Verification
The assertions check four things on every cycle:
- mode_o never holds an illegal extended code.
- A busy engine without force freezes the mode.
- Force moves the requested code into effect on the next edge.
- Disabling the port returns it to manual, off mode pins are fixed, and the interrupt flag only rises after an event.

Only the bench scenarios show the rest:
- pin levels for every control and inversion combination;
- the per-mode split between register-owned and engine-owned signals;
- the status bit layout after synchronisation;
- that illegal writes still update the other configuration fields.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int unsigned CTL_W = 5;
  localparam int unsigned IN_W  = 5;
  localparam int unsigned WR_W  = 32;
  localparam int unsigned STAT_W = 16;

  // control signal index, shared by control register, engine bus and inversion bits
  localparam int unsigned SIG_INIT   = 0;
  localparam int unsigned SIG_STRB   = 1;
  localparam int unsigned SIG_AUTOFD = 2;
  localparam int unsigned SIG_SELI   = 3;
  localparam int unsigned SIG_OE     = 4;

  // configuration word field positions
  localparam int unsigned CF_MODE_LO = 0;
  localparam int unsigned CF_EXT     = 3;
  localparam int unsigned CF_FORCE   = 4;
  localparam int unsigned CF_EN      = 5;
  localparam int unsigned CF_WIDE    = 6;
  localparam int unsigned CF_OINV_LO = 8;
  localparam int unsigned CF_IINV_LO = 16;

  // control word field positions
  localparam int unsigned CW_CTL_LO  = 16;
  localparam int unsigned CW_IRQ_ACK = 24;

  typedef logic [3:0] pmode_t;

  localparam pmode_t MD_MANUAL = 4'h0;
  localparam pmode_t MD_CENTR  = 4'h1;
  localparam pmode_t MD_FASTB  = 4'h2;
  localparam pmode_t MD_NIBBLE = 4'h3;
  localparam pmode_t MD_BYTE   = 4'h4;
  localparam pmode_t MD_OFF    = 4'h7;

  typedef struct packed {
    pmode_t            mode;
    logic              force_now;
    logic              enable;
    logic              wide;
    logic [CTL_W-1:0]  out_inv;
    logic [IN_W-1:0]   in_inv;
  } pcfg_t;

  // extended codes are only valid with low bits 000, 101, 110 or 111
  function automatic logic mode_ok(pmode_t c);
    return !c[3] || (c[2:0] == 3'd0) || (c[2:0] >= 3'd5);
  endfunction
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) begin
        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/pport_cfg_regs.sv
module pport_cfg_regs
  import pport_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [WR_W-1:0] wdata,
  output pcfg_t           cfg_q
);
  pcfg_t  cfg_d;
  pmode_t wr_mode;
  logic   unused_cfg_bits;

  assign unused_cfg_bits = ^{wdata[WR_W-1:CF_IINV_LO+IN_W],
                             wdata[CF_IINV_LO-1:CF_OINV_LO+CTL_W],
                             wdata[CF_OINV_LO-1:CF_WIDE+1]};

  always_comb begin
    wr_mode = {wdata[CF_EXT], wdata[CF_MODE_LO +: 3]};
    cfg_d   = cfg_q;
    if (mode_ok(wr_mode)) begin
      cfg_d.mode = wr_mode;
    end
    cfg_d.force_now = wdata[CF_FORCE];
    cfg_d.enable    = wdata[CF_EN];
    cfg_d.wide      = wdata[CF_WIDE];
    cfg_d.out_inv   = wdata[CF_OINV_LO +: CTL_W];
    cfg_d.in_inv    = wdata[CF_IINV_LO +: IN_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_wr) begin
      cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/pport_mode_sel.sv
module pport_mode_sel
  import pport_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enable,
  input  logic   force_now,
  input  logic   eng_busy,
  input  pmode_t req_mode,
  output pmode_t eff_mode
);
  pmode_t eff_d;
  logic   take;

  always_comb begin
    take = (req_mode != eff_mode) && (force_now || !eng_busy);
    if (!enable) begin
      eff_d = MD_MANUAL;
    end else if (take) begin
      eff_d = req_mode;
    end else begin
      eff_d = eff_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_mode <= MD_MANUAL;
    end else begin
      eff_mode <= eff_d;
    end
  end
endmodule

// File: rtl/pport_ctl_regs.sv
module pport_ctl_regs
  import pport_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              ctl_wr,
  input  logic              ctl_byte_wr,
  input  logic [WR_W-1:0]   wdata,
  input  logic              periph_evt,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [DATA_W-1:0] data_q,
  output logic              irq_q
);
  logic [CTL_W-1:0]  ctl_d;
  logic [DATA_W-1:0] data_d;
  logic              irq_d;
  logic              unused_ctl_bits;

  assign unused_ctl_bits = ^{wdata[WR_W-1:CW_IRQ_ACK+1],
                             wdata[CW_IRQ_ACK-1:CW_CTL_LO+CTL_W],
                             wdata[CW_CTL_LO-1:DATA_W]};

  always_comb begin
    ctl_d  = ctl_q;
    data_d = data_q;
    irq_d  = irq_q;
    if (ctl_wr) begin
      ctl_d  = wdata[CW_CTL_LO +: CTL_W];
      data_d = wdata[DATA_W-1:0];
      if (wdata[CW_IRQ_ACK]) begin
        irq_d = 1'b0;
      end
    end else if (ctl_byte_wr) begin
      ctl_d = wdata[CTL_W-1:0];
    end
    if (periph_evt) begin
      irq_d = 1'b1;
    end
    if (!enable) begin
      ctl_d  = '0;
      data_d = '0;
      irq_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      data_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      data_q <= data_d;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/pport_pin_drv.sv
module pport_pin_drv
  import pport_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  pmode_t            eff_mode,
  input  logic [CTL_W-1:0]  ctl_q,
  input  logic [DATA_W-1:0] data_q,
  input  logic [CTL_W-1:0]  eng_ctl,
  input  logic [DATA_W-1:0] eng_data,
  input  logic [CTL_W-1:0]  out_inv,
  output logic [CTL_W-1:0]  pin_ctl,
  output logic [DATA_W-1:0] pin_data
);
  logic [CTL_W-1:0] act;
  logic             reg_init;
  logic             reg_autofd;
  logic             off_mode;

  always_comb begin
    reg_init   = (eff_mode == MD_CENTR) || (eff_mode == MD_FASTB) ||
                 (eff_mode == MD_NIBBLE) || (eff_mode == MD_BYTE);
    reg_autofd = (eff_mode == MD_CENTR) || (eff_mode == MD_FASTB);
    off_mode   = (eff_mode == MD_OFF);
    if (eff_mode == MD_MANUAL) begin
      act      = ctl_q;
      pin_data = data_q;
    end else begin
      act      = eng_ctl;
      pin_data = eng_data;
      if (reg_init) begin
        act[SIG_INIT] = ctl_q[SIG_INIT];
      end
      if (reg_autofd) begin
        act[SIG_AUTOFD] = ctl_q[SIG_AUTOFD];
      end
    end
    if (off_mode) begin
      act      = '0;
      pin_data = data_q;
    end
  end

  for (genvar g = 0; g < int'(CTL_W); g++) begin : g_pin
    if (g == int'(SIG_OE)) begin : g_oe
      assign pin_ctl[g] = act[g] ^ out_inv[g];
    end else begin : g_ctl
      localparam logic OFF_LVL = (g == int'(SIG_SELI)) ? 1'b0 : 1'b1;
      assign pin_ctl[g] = off_mode ? OFF_LVL : (~act[g] ^ out_inv[g]);
    end
  end
endmodule

// File: rtl/pport_modectl.sv
module pport_modectl
  import pport_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              ctl_wr,
  input  logic              ctl_byte_wr,
  input  logic [WR_W-1:0]   wdata,
  input  logic              eng_busy,
  input  logic [CTL_W-1:0]  eng_ctl,
  input  logic [DATA_W-1:0] eng_data,
  input  logic              rx_avail,
  input  logic              tx_ready,
  input  logic              periph_evt,
  input  logic              pin_perr,
  input  logic              pin_ack_n,
  input  logic              pin_busy,
  input  logic              pin_fault_n,
  input  logic              pin_sel,
  output logic              pin_seli_n,
  output logic              pin_autofd_n,
  output logic              pin_strb_n,
  output logic              pin_init_n,
  output logic              pin_data_oe,
  output logic [DATA_W-1:0] pin_data,
  output logic [3:0]        mode_o,
  output logic              irq_pend,
  output logic [STAT_W-1:0] status_o
);
  logic [1:0]        rst_pipe;
  logic              rst_sn;
  pcfg_t             cfg_q;
  pmode_t            req_mode;
  logic              cfg_force;
  logic              cfg_en;
  logic [CTL_W-1:0]  ctl_q;
  logic [DATA_W-1:0] data_q;
  logic [CTL_W-1:0]  pin_ctl;
  logic [IN_W-1:0]   in_raw;
  logic [IN_W-1:0]   in_sync;
  logic [IN_W-1:0]   in_cond;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sn = rst_pipe[1];

  pport_cfg_regs u_cfg (
    .clk    (clk),
    .rst_n  (rst_sn),
    .cfg_wr (cfg_wr),
    .wdata  (wdata),
    .cfg_q  (cfg_q)
  );

  assign req_mode  = cfg_q.mode;
  assign cfg_force = cfg_q.force_now;
  assign cfg_en    = cfg_q.enable;

  pport_mode_sel u_mode (
    .clk       (clk),
    .rst_n     (rst_sn),
    .enable    (cfg_en),
    .force_now (cfg_force),
    .eng_busy  (eng_busy),
    .req_mode  (req_mode),
    .eff_mode  (mode_o)
  );

  pport_ctl_regs #(.DATA_W(DATA_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_sn),
    .enable      (cfg_en),
    .ctl_wr      (ctl_wr),
    .ctl_byte_wr (ctl_byte_wr),
    .wdata       (wdata),
    .periph_evt  (periph_evt),
    .ctl_q       (ctl_q),
    .data_q      (data_q),
    .irq_q       (irq_pend)
  );

  pport_pin_drv #(.DATA_W(DATA_W)) u_pins (
    .eff_mode (mode_o),
    .ctl_q    (ctl_q),
    .data_q   (data_q),
    .eng_ctl  (eng_ctl),
    .eng_data (eng_data),
    .out_inv  (cfg_q.out_inv),
    .pin_ctl  (pin_ctl),
    .pin_data (pin_data)
  );

  assign pin_init_n   = pin_ctl[SIG_INIT];
  assign pin_strb_n   = pin_ctl[SIG_STRB];
  assign pin_autofd_n = pin_ctl[SIG_AUTOFD];
  assign pin_seli_n   = pin_ctl[SIG_SELI];
  assign pin_data_oe  = pin_ctl[SIG_OE];

  assign in_raw = {pin_perr, pin_ack_n, pin_busy, pin_fault_n, pin_sel};

  pport_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     (in_raw),
    .q     (in_sync)
  );

  assign in_cond  = in_sync ^ cfg_q.in_inv;
  assign status_o = {mode_o[2:0], in_cond, mode_o[3], cfg_q.wide, 4'b0000,
                     tx_ready, rx_avail};
endmodule

// File: rtl/pport_modectl_chk.sv
module pport_modectl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mode_o,
  input logic [3:0] req_mode,
  input logic       force_now,
  input logic       en,
  input logic       eng_busy,
  input logic       periph_evt,
  input logic       irq,
  input logic       seli_n,
  input logic       autofd_n,
  input logic       strb_n,
  input logic       init_n
);
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o[3] |-> ((mode_o[2:0] == 3'd0) || (mode_o[2:0] >= 3'd5))); // R2

  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && eng_busy && !force_now) |=> $stable(mode_o)); // R4

  AST_FORCE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && force_now) |=> (mode_o == $past(req_mode))); // R5

  AST_DISABLE_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (mode_o == 4'h0)); // R12

  AST_OFF_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 4'h7) |-> (!seli_n && autofd_n && strb_n && init_n)); // R9

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(periph_evt)); // R13
endmodule

bind pport_modectl pport_modectl_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_sn),
  .mode_o     (mode_o),
  .req_mode   (req_mode),
  .force_now  (cfg_force),
  .en         (cfg_en),
  .eng_busy   (eng_busy),
  .periph_evt (periph_evt),
  .irq        (irq_pend),
  .seli_n     (pin_seli_n),
  .autofd_n   (pin_autofd_n),
  .strb_n     (pin_strb_n),
  .init_n     (pin_init_n)
);

// File: tb/pport_modectl_tb.sv
module pport_modectl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic          cfg_wr, ctl_wr, ctl_byte_wr;
  logic [31:0]   wdata;
  logic          eng_busy;
  logic [4:0]    eng_ctl;
  logic [DW-1:0] eng_data;
  logic          rx_avail, tx_ready, periph_evt;
  logic          pin_perr, pin_ack_n, pin_busy, pin_fault_n, pin_sel;
  logic          pin_seli_n, pin_autofd_n, pin_strb_n, pin_init_n, pin_data_oe;
  logic [DW-1:0] pin_data;
  logic [3:0]    mode_o;
  logic          irq_pend;
  logic [15:0]   status_o;

  int n_tests = 0;
  int n_fail  = 0;

  pport_modectl #(.DATA_W(DW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .ctl_wr(ctl_wr),
    .ctl_byte_wr(ctl_byte_wr), .wdata(wdata), .eng_busy(eng_busy),
    .eng_ctl(eng_ctl), .eng_data(eng_data), .rx_avail(rx_avail),
    .tx_ready(tx_ready), .periph_evt(periph_evt), .pin_perr(pin_perr),
    .pin_ack_n(pin_ack_n), .pin_busy(pin_busy), .pin_fault_n(pin_fault_n),
    .pin_sel(pin_sel), .pin_seli_n(pin_seli_n), .pin_autofd_n(pin_autofd_n),
    .pin_strb_n(pin_strb_n), .pin_init_n(pin_init_n), .pin_data_oe(pin_data_oe),
    .pin_data(pin_data), .mode_o(mode_o), .irq_pend(irq_pend), .status_o(status_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk_cfg(logic [2:0] m, logic ext, logic frc,
                                         logic en, logic wide, logic [4:0] oinv,
                                         logic [4:0] iinv);
    return {11'b0, iinv, 3'b0, oinv, 1'b0, wide, en, frc, ext, m};
  endfunction

  // expected pin levels, index 0 init_n, 1 strb_n, 2 autofd_n, 3 seli_n, 4 oe
  function automatic logic [4:0] exp_pins(logic [3:0] m, logic [4:0] c,
                                          logic [4:0] e, logic [4:0] inv);
    logic [4:0] a;
    logic [4:0] p;
    if (m == 4'h7) return {inv[4], 4'b0111};
    a = (m == 4'h0) ? c : e;
    if (m >= 4'h1 && m <= 4'h4) a[0] = c[0];
    if (m == 4'h1 || m == 4'h2) a[2] = c[2];
    p[3:0] = ~a[3:0] ^ inv[3:0];
    p[4]   = a[4] ^ inv[4];
    return p;
  endfunction

  function automatic logic [4:0] pins_now();
    return {pin_data_oe, pin_seli_n, pin_autofd_n, pin_strb_n, pin_init_n};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [31:0] v);
    @(negedge clk); cfg_wr = 1'b1; wdata = v;
    @(negedge clk); cfg_wr = 1'b0; wdata = '0;
  endtask

  task automatic ctl_write(input logic [4:0] c, input logic [7:0] d, input logic ack);
    @(negedge clk); ctl_wr = 1'b1; wdata = {7'b0, ack, 3'b0, c, 8'b0, d};
    @(negedge clk); ctl_wr = 1'b0; wdata = '0;
  endtask

  task automatic byte_write(input logic [31:0] v);
    @(negedge clk); ctl_byte_wr = 1'b1; wdata = v;
    @(negedge clk); ctl_byte_wr = 1'b0; wdata = '0;
  endtask

  task automatic evt_pulse();
    @(negedge clk); periph_evt = 1'b1;
    @(negedge clk); periph_evt = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] prev;
    rst_n = 1'b0; cfg_wr = 0; ctl_wr = 0; ctl_byte_wr = 0; wdata = '0;
    eng_busy = 0; eng_ctl = '0; eng_data = '0; rx_avail = 0; tx_ready = 0;
    periph_evt = 0; pin_perr = 0; pin_ack_n = 0; pin_busy = 0; pin_fault_n = 0; pin_sel = 0;
    tick(3);
    rst_n = 1'b1;
    tick(5);

    // R1 reset state
    chk("R1 mode", {28'b0, mode_o}, 32'h0);
    chk("R1 pins", {27'b0, pins_now()}, 32'h0F);
    chk("R1 data", {24'b0, pin_data}, 32'h0);
    chk("R1 irq", {31'b0, irq_pend}, 32'h0);
    chk("R1 status", {16'b0, status_o}, 32'h0);

    // R2/R3 sweep of all 16 codes with force
    cfg_write(mk_cfg(3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 5'h0, 5'h0));
    tick(1);
    prev = 4'h0;
    for (int code = 0; code < 16; code++) begin
      logic [3:0] cd;
      cd = 4'(code);
      cfg_write(mk_cfg(cd[2:0], cd[3], 1'b1, 1'b1, 1'b0, 5'h0, 5'h0));
      tick(1);
      if (!cd[3] || cd[2:0] == 3'd0 || cd[2:0] >= 3'd5) prev = cd;
      chk("R2/R3 mode sweep", {28'b0, mode_o}, {28'b0, prev});
      chk("R11 status mode", {29'b0, status_o[15:13]}, {29'b0, prev[2:0]});
      chk("R11 status ext", {31'b0, status_o[7]}, {31'b0, prev[3]});
    end

    // R3 illegal code keeps mode but writes inversion
    cfg_write(mk_cfg(3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 5'h0, 5'h0));
    tick(1);
    ctl_write(5'h0, 8'h00, 1'b0);
    cfg_write(mk_cfg(3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 5'h1F, 5'h0));
    tick(1);
    chk("R3 mode kept", {28'b0, mode_o}, 32'h0);
    chk("R3 inversion applied", {27'b0, pins_now()}, {27'b0, exp_pins(4'h0, 5'h0, 5'h0, 5'h1F)});

    // R6/R8 manual sweep over control and output inversion
    for (int inv = 0; inv < 32; inv++) begin
      cfg_write(mk_cfg(3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 5'(inv), 5'h0));
      for (int c = 0; c < 32; c++) begin
        logic [7:0] d;
        d = 8'(c * 7 + inv * 3);
        ctl_write(5'(c), d, 1'b0);
        chk("R6/R8 manual pins", {27'b0, pins_now()},
            {27'b0, exp_pins(4'h0, 5'(c), 5'h0, 5'(inv))});
        chk("R6 manual data", {24'b0, pin_data}, {24'b0, d});
      end
    end

    // R7 byte write
    cfg_write(mk_cfg(3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 5'h0, 5'h0));
    ctl_write(5'h00, 8'hA5, 1'b0);
    byte_write(32'h0000_00F3);
    chk("R7 byte ctl", {27'b0, pins_now()}, {27'b0, exp_pins(4'h0, 5'h13, 5'h0, 5'h0)});
    chk("R7 data kept", {24'b0, pin_data}, 32'hA5);

    // R10 engine-owned modes
    foreach (eng_ctl[i]) ; // no-op
    for (int k = 0; k < 10; k++) begin
      logic [3:0] m;
      m = (k < 6) ? 4'(k + 1) : ((k == 6) ? 4'h8 : 4'(k + 6));
      for (int pat = 0; pat < 2; pat++) begin
        logic [4:0] c, e, inv;
        c   = pat ? 5'b11010 : 5'b00101;
        e   = pat ? 5'b00101 : 5'b11010;
        inv = pat ? 5'h0A : 5'h00;
        cfg_write(mk_cfg(m[2:0], m[3], 1'b1, 1'b1, 1'b0, inv, 5'h0));
        ctl_write(c, 8'h5A, 1'b0);
        eng_ctl = e; eng_data = pat ? 8'hC3 : 8'h3C;
        tick(1);
        chk("R10 mode", {28'b0, mode_o}, {28'b0, m});
        chk("R10 engine pins", {27'b0, pins_now()}, {27'b0, exp_pins(m, c, e, inv)});
        chk("R10 engine data", {24'b0, pin_data}, {24'b0, (pat ? 8'hC3 : 8'h3C)});
      end
    end
    eng_ctl = '0; eng_data = '0;

    // R9 off mode across all inversions
    for (int inv = 0; inv < 32; inv++) begin
      cfg_write(mk_cfg(3'd7, 1'b0, 1'b1, 1'b1, 1'b0, 5'(inv), 5'h0));
      ctl_write(5'h1F, 8'h00, 1'b0);
      chk("R9 off pins", {27'b0, pins_now()}, {27'b0, exp_pins(4'h7, 5'h1F, 5'h0, 5'(inv))});
    end

    // R11 input conditioning sweep
    cfg_write(mk_cfg(3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 5'h0, 5'h0));
    tick(1);
    for (int p = 0; p < 32; p++) begin
      logic [4:0] pv;
      pv = 5'(p);
      @(negedge clk);
      {pin_perr, pin_ack_n, pin_busy, pin_fault_n, pin_sel} = pv;
      rx_avail = pv[0]; tx_ready = pv[1];
      tick(2);
      for (int inv = 0; inv < 32; inv++) begin
        logic [4:0] iv;
        iv = 5'(inv);
        cfg_write(mk_cfg(3'd0, 1'b0, 1'b1, 1'b1, iv[0], 5'h0, iv));
        chk("R11 status word", {16'b0, status_o},
            {16'b0, 3'b000, pv ^ iv, 1'b0, iv[0], 4'b0000, pv[1], pv[0]});
      end
    end
    @(negedge clk);
    {pin_perr, pin_ack_n, pin_busy, pin_fault_n, pin_sel} = '0;
    rx_avail = 0; tx_ready = 0;

    // R4 deferred change
    cfg_write(mk_cfg(3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 5'h0, 5'h0));
    tick(1);
    @(negedge clk); eng_busy = 1'b1;
    cfg_write(mk_cfg(3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 5'h0, 5'h0));
    tick(3);
    chk("R4 held while busy", {28'b0, mode_o}, 32'h0);
    chk("R4 status shows old", {29'b0, status_o[15:13]}, 32'h0);
    eng_busy = 1'b0;
    tick(1);
    chk("R4 taken at idle", {28'b0, mode_o}, 32'h1);
    @(negedge clk); eng_busy = 1'b1;
    cfg_write(mk_cfg(3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 5'h0, 5'h0));
    tick(2);
    chk("R4 EPP held while busy", {28'b0, mode_o}, 32'h1);
    eng_busy = 1'b0;
    tick(1);
    chk("R4 EPP read taken", {28'b0, mode_o}, 32'h8);

    // R5 force while busy
    @(negedge clk); eng_busy = 1'b1;
    cfg_write(mk_cfg(3'd5, 1'b0, 1'b1, 1'b1, 1'b0, 5'h0, 5'h0));
    tick(1);
    chk("R5 forced while busy", {28'b0, mode_o}, 32'h5);
    eng_busy = 1'b0;

    // R12 disable
    ctl_write(5'h1F, 8'h3C, 1'b0);
    evt_pulse();
    chk("R13 irq set", {31'b0, irq_pend}, 32'h1);
    cfg_write(mk_cfg(3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 5'h0, 5'h0));
    tick(1);
    chk("R12 mode manual", {28'b0, mode_o}, 32'h0);
    chk("R12 pins idle", {27'b0, pins_now()}, 32'h0F);
    chk("R12 data cleared", {24'b0, pin_data}, 32'h0);
    chk("R12 irq cleared", {31'b0, irq_pend}, 32'h0);
    ctl_write(5'h1F, 8'hFF, 1'b0);
    chk("R12 write ignored pins", {27'b0, pins_now()}, 32'h0F);
    chk("R12 write ignored data", {24'b0, pin_data}, 32'h0);

    // R13 interrupt flag
    cfg_write(mk_cfg(3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 5'h0, 5'h0));
    tick(1);
    evt_pulse();
    chk("R13 set by event", {31'b0, irq_pend}, 32'h1);
    ctl_write(5'h0, 8'h0, 1'b0);
    chk("R13 no ack keeps", {31'b0, irq_pend}, 32'h1);
    ctl_write(5'h0, 8'h0, 1'b1);
    chk("R13 ack clears", {31'b0, irq_pend}, 32'h0);
    evt_pulse();
    @(negedge clk); periph_evt = 1'b1; ctl_wr = 1'b1; wdata = 32'h0100_0000;
    @(negedge clk); periph_evt = 1'b0; ctl_wr = 1'b0; wdata = '0;
    chk("R13 event wins over ack", {31'b0, irq_pend}, 32'h1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule